// File: doc/BRIEF.md
# Fractional-Slot Baud Tick Generator

This block produces the 16x oversampling tick that drives a UART's transmit and receive shifters. It counts events from one of three sources, picked by a 2-bit field: the bus clock, an external clock, or a PLL clock. One tick period normally lasts `divisor + 1` source events. A 16-bit slot mask can add one extra event to chosen tick periods of a bit. Setting k of the 16 mask bits places the average bit rate k/16 of the way between two neighbouring integer divisors.

The block runs entirely in the bus-clock domain. The external and PLL clocks arrive as single-cycle event pulses, already synchronized, and a pulse marks one edge of that source. After the sixteenth tick of each bit, the tick index returns to zero and a bit-boundary strobe fires together with that tick. Software loads the divisor and the mask. The generator copies both into shadow registers only at tick boundaries, or while it is disabled, so a write never splits a tick period.

Top module: `frac_baud_gen`

## Requirements
- R1: During reset and on the first cycles after it, `os_tick` and `bit_strobe` are low.
- R2: With the current mask bit at 0, every tick period lasts exactly `divisor + 1` source events. `os_tick` is a one-cycle pulse in the cycle after the edge that completes the period.
- R3: Tick period k (k = 0..15, counted from the first tick period after enable) lasts one extra source event when bit k of `slot` is 1.
- R4: `bit_strobe` is high together with every 16th tick, and only then. That is the tick that ends tick period 15, when the index wraps to 0.
- R5: `clk_sel` value 0 or 2 counts one event per bus-clock cycle. Value 1 counts `ext_ce` pulses, and value 3 counts `pll_ce` pulses. Pulses on the source that is not selected have no effect on tick timing.
- R6: A change to `divisor` or `slot` in the middle of a tick period does not alter that period. The new values apply from the next tick period onward.
- R7: While `enable` is low, no ticks or strobes are produced and the counters return to zero. After enable rises, the first tick comes `divisor + 1 + slot[0]` events later.
- R8: A tick is produced only in the cycle after an edge at which the selected source had an event.
- R9: With the bus clock selected, the distance between two bit strobes is `16*(divisor+1) + popcount(slot)` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is clocked here |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable; low holds counters at zero |
| clk_sel | input | 2 | Source select: 0/2 bus, 1 external, 3 PLL |
| ext_ce | input | 1 | One-cycle event pulse from the external clock |
| pll_ce | input | 1 | One-cycle event pulse from the PLL clock |
| divisor | input | DIV_W (16) | Integer divisor; a tick period is divisor+1 events |
| slot | input | 16 | Per-tick dither mask; bit k lengthens tick period k |
| os_tick | output | 1 | Oversampling tick pulse |
| bit_strobe | output | 1 | Bit-boundary pulse on the 16th tick |

## Verification
The embedded assertions check some rules on every cycle. A strobe always coincides with a tick. A disabled block clears its counters and stays quiet. No tick follows a cycle without a source event. The shadow divisor and mask hold steady inside a tick period, and the event counter never passes its limit. The exact period lengths need the bench's cycle-level reference model and its scenarios to show: the placement of the dithered periods, the 67-cycle bit length for mask 0x0888, the deferred effect of mid-period writes, and the indifference to pulses on the unselected source.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Oversampling ratio: ticks per bit, and the width of the tick index
    localparam int OSR   = 16;
    localparam int IDX_W = $clog2(OSR);

    // Source selection codes; two codes map to the bus clock
    typedef enum logic [1:0] {
        SRC_BUS_A = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_BUS_B = 2'd2,
        SRC_PLL   = 2'd3
    } src_sel_e;

endpackage

// File: rtl/baud_src_sel.sv
module baud_src_sel
    import baud_pkg::*;
(
    input  logic [1:0] sel,
    input  logic       ext_ce,
    input  logic       pll_ce,
    output logic       src_evt
);

    src_sel_e sel_e;

    always_comb begin
        sel_e = src_sel_e'(sel);
        unique case (sel_e)
            SRC_EXT:  src_evt = ext_ce;
            SRC_PLL:  src_evt = pll_ce;
            default:  src_evt = 1'b1;   // bus clock: an event every cycle
        endcase
    end

endmodule

// File: rtl/baud_tick_core.sv
module baud_tick_core
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             src_evt,
    input  logic [DIV_W-1:0] div_in,
    input  logic [OSR-1:0]   slot_in,
    output logic             tick_o,
    output logic             wrap_o
);

    localparam int CNT_W = DIV_W + 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(OSR - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
        logic [DIV_W-1:0] div;
        logic [OSR-1:0]   slot;
        logic             tick;
        logic             wrap;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [CNT_W-1:0] limit;
    logic             at_limit;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        st_d.wrap = 1'b0;
        // dithered period end: divisor plus the mask bit of this tick
        limit     = {1'b0, st_q.div} + CNT_W'(st_q.slot[st_q.idx]);
        at_limit  = (st_q.cnt == limit);
        if (!en) begin
            st_d.cnt  = '0;
            st_d.idx  = '0;
            st_d.div  = div_in;
            st_d.slot = slot_in;
        end else if (src_evt) begin
            if (at_limit) begin
                st_d.cnt  = '0;
                st_d.idx  = (st_q.idx == IDX_LAST) ? '0 : st_q.idx + 1'b1;
                st_d.div  = div_in;
                st_d.slot = slot_in;
                st_d.tick = 1'b1;
                st_d.wrap = (st_q.idx == IDX_LAST);
            end else begin
                st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick_o = st_q.tick;
    assign wrap_o = st_q.wrap;

    a_r4_wrap_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wrap |-> st_q.tick);

    a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.cnt == '0 && st_q.idx == '0 && !st_q.tick));

    a_r8_tick_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
        !src_evt |=> !st_q.tick);

    a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en) && !st_q.tick) |-> ($stable(st_q.div) && $stable(st_q.slot)));

    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= ({1'b0, st_q.div} + 1'b1));

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import baud_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [1:0]       clk_sel,
    input  logic             ext_ce,
    input  logic             pll_ce,
    input  logic [DIV_W-1:0] divisor,
    input  logic [OSR-1:0]   slot,
    output logic             os_tick,
    output logic             bit_strobe
);

    logic src_evt;

    baud_src_sel u_sel (
        .sel     (clk_sel),
        .ext_ce  (ext_ce),
        .pll_ce  (pll_ce),
        .src_evt (src_evt)
    );

    baud_tick_core #(.DIV_W(DIV_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (enable),
        .src_evt (src_evt),
        .div_in  (divisor),
        .slot_in (slot),
        .tick_o  (os_tick),
        .wrap_o  (bit_strobe)
    );

    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!os_tick && !bit_strobe));

endmodule

// File: tb/sim_frac_baud_gen.sv
module sim_frac_baud_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [1:0]  clk_sel = 2'd0;
    logic        ext_ce = 1'b0;
    logic        pll_ce = 1'b0;
    logic [15:0] divisor = 16'd3;
    logic [15:0] slot = 16'h0000;
    logic        os_tick, bit_strobe;

    always #5 clk = ~clk;   // 100 MHz

    frac_baud_gen u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
        .ext_ce(ext_ce), .pll_ce(pll_ce), .divisor(divisor), .slot(slot),
        .os_tick(os_tick), .bit_strobe(bit_strobe)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    logic [15:0] lf = 16'hACE1;
    int    cyc = 0;

    // reference model: remaining events in the current tick period
    int          left;
    int          ridx;
    int          sdiv;
    logic [15:0] sslot;
    logic        exp_tick, exp_bit;

    function automatic logic evt_now();
        if (clk_sel == 2'd1) return ext_ce;
        if (clk_sel == 2'd3) return pll_ce;
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n || !enable) begin
            ridx = 0; sdiv = int'(divisor); sslot = slot;
            left = sdiv + 1 + int'(sslot[0]);
            exp_tick = 1'b0; exp_bit = 1'b0;
        end else if (evt_now()) begin
            left = left - 1;
            exp_tick = 1'b0; exp_bit = 1'b0;
            if (left == 0) begin
                exp_tick = 1'b1;
                exp_bit  = (ridx == 15);
                ridx = (ridx + 1) % 16;
                sdiv = int'(divisor); sslot = slot;
                left = sdiv + 1 + int'(sslot[ridx]);
            end
        end else begin
            exp_tick = 1'b0; exp_bit = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, expv, cyc);
        end
    endtask

    // one cycle: compare at the falling edge, then drive source pulses
    task automatic step(input bit rnd);
        @(negedge clk);
        cyc++;
        check(os_tick === exp_tick, {cur_req, " os_tick"}, int'(os_tick), int'(exp_tick));
        check(bit_strobe === exp_bit, {cur_req, " bit_strobe"}, int'(bit_strobe), int'(exp_bit));
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        if (rnd) begin
            ext_ce = lf[0] & lf[3];
            pll_ce = lf[5];
        end else begin
            ext_ce = 1'b0; pll_ce = 1'b0;
        end
    endtask

    task automatic run(input int n, input bit rnd);
        for (int i = 0; i < n; i++) step(rnd);
    endtask

    int t_a, t_b, first_gap;

    initial begin
        // R1: reset state
        cur_req = "R1";
        run(4, 1'b0);
        check(os_tick === 1'b0 && bit_strobe === 1'b0, "R1 reset outputs", int'(os_tick), 0);
        rst_n = 1'b1;
        run(4, 1'b0);
        check(os_tick === 1'b0, "R1 idle after reset", int'(os_tick), 0);

        // R2 / R7: plain divisor, first tick after enable
        cur_req = "R2";
        divisor = 16'd3; slot = 16'h0000; enable = 1'b1;
        first_gap = 0;
        for (int i = 0; i < 20; i++) begin
            step(1'b0);
            if (os_tick === 1'b1 && first_gap == 0) first_gap = i + 1;
        end
        check(first_gap == 4, "R7 first tick distance", first_gap, 4);
        run(120, 1'b0);

        // R3: single lengthened period
        cur_req = "R3";
        enable = 1'b0; run(3, 1'b0);
        slot = 16'h0080; enable = 1'b1;
        run(200, 1'b0);
        slot = 16'hFFDF; run(300, 1'b0);

        // R9 / R4: bit length with mask 0x0888 (three extra events)
        cur_req = "R9";
        enable = 1'b0; run(2, 1'b0);
        divisor = 16'd3; slot = 16'h0888; enable = 1'b1;
        t_a = -1; t_b = -1;
        for (int i = 0; i < 200 && t_b < 0; i++) begin
            step(1'b0);
            if (bit_strobe === 1'b1) begin
                if (t_a < 0) t_a = cyc; else t_b = cyc;
            end
        end
        check((t_b - t_a) == 67, "R9 strobe spacing", t_b - t_a, 67);
        check(t_a > 0 && t_b > 0, "R4 strobes seen", t_b, 1);

        // R6: mid-period writes
        cur_req = "R6";
        run(2, 1'b0);
        divisor = 16'd9; run(5, 1'b0);
        slot = 16'h5555; divisor = 16'd1; run(80, 1'b0);
        divisor = 16'd0; slot = 16'h0000; run(40, 1'b0);

        // R5: external and PLL pulses, the other source toggling
        cur_req = "R5";
        divisor = 16'd2; slot = 16'h4924;
        clk_sel = 2'd1; run(600, 1'b1);
        clk_sel = 2'd3; run(600, 1'b1);
        clk_sel = 2'd2; run(200, 1'b1);

        // R8: selected source silent
        cur_req = "R8";
        clk_sel = 2'd1; run(50, 1'b0);
        check(os_tick === 1'b0, "R8 no tick without events", int'(os_tick), 0);

        // R7: disable mid-bit, then restart
        cur_req = "R7";
        clk_sel = 2'd0; run(37, 1'b0);
        enable = 1'b0; run(30, 1'b0);
        divisor = 16'd5; slot = 16'hDFDF; enable = 1'b1;
        run(400, 1'b0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule